// File: doc/BRIEF.md
# Symbol Path Loopback and Bypass Controller

This block sits in the physical-layer data path of a ring network that moves 5-bit line symbols, paired into 10-bit symbol pairs on the MAC side. A host writes a small control word. That word selects two local loopbacks, a remote loopback, a physical bypass, a repeat-filter hold and a self-test start bit. A connection-management state input controls when the local-loopback bits may be written. The same input, together with a configuration-override pin, controls when the bypass and remote loopback act on the data.

The block joins consecutive received line symbols into pairs and presents that pair stream at the framer input. It takes the elasticity-buffer output back through a port and routes the result to the MAC receive output. On the transmit side it sends either the MAC pair or, under remote loopback, the receive-path pair to the line. The framer, the elasticity buffer and the self-test engine lie outside this block. A registered select output takes the place of the clock switch that the framer-side loopback needs, so the whole block runs on one clock.

Top module: `sym_path_ctrl`

## Requirements
- R1: Control-word bit 0 (post-buffer loop) and bit 1 (framer loop) are updated by a write only while `mgmt_state` is 0 (off) or 1 (maintenance). A write in any other state leaves both bits unchanged.
- R2: Bits 2 (remote loop), 3 (bypass), 4 (filter hold) and 5 (self-test) are updated by every write. Bypass and remote loop act only while `mgmt_state` is 1 or `cfg_override` is 1.
- R3: While the bypass acts and `scrub_req` is 1, `rx_pair` carries the Idle pair 10'h3FF one cycle later.
- R4: While the bypass acts and `scrub_req` is 0, `rx_pair` carries `tx_pair` one cycle later. Without the bypass, `rx_pair` carries the post-buffer receive data, which is `eb_pair` unless R7 applies.
- R5: The remote loop sends `eb_pair` to `tx_line` one cycle later only when it acts (R2), neither local loop is in effect and `cipher_loop` is 0. In every other case `tx_line` carries `tx_pair`.
- R6: While the framer loop is in effect, `framer_data` carries `tx_pair` and `clk_sel_local` is 1. Otherwise `framer_data` carries the pair made from two consecutive `rx_line` symbols, with the earlier symbol in bits 9:5, and `clk_sel_local` is 0.
- R7: The post-buffer loop replaces `eb_pair` with `tx_pair` on the receive path. It takes priority over the framer loop, and either local loop takes priority over the remote loop.
- R8: Setting bit 5 raises `selftest_run` and forces the framer loop on. A `selftest_done` pulse while the test runs gives a one-cycle `selftest_irq` and ends the run. Clearing bit 5 before completion aborts the run, and no interrupt follows.
- R9: After completion, writing bit 5 as 1 again does not restart the test. The bit must first be written 0 and then 1.
- R10: `filter_hold` follows control bit 4.
- R11: During reset, every output is 0 and all control bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 6 | Control word to write |
| mgmt_state | input | 3 | Connection-management state (0 off, 1 maintenance) |
| cfg_override | input | 1 | Lets bypass and remote loop act outside maintenance |
| cipher_loop | input | 1 | Cipher loopback active; blocks the remote loop |
| scrub_req | input | 1 | Scrub request; bypass drives Idle |
| selftest_done | input | 1 | Completion pulse from the self-test engine |
| tx_pair | input | 10 | Transmit symbol pair from the MAC |
| eb_pair | input | 10 | Pair returned by the elasticity buffer |
| rx_line | input | 5 | Received line symbol |
| rx_pair | output | 10 | Receive symbol pair to the MAC |
| tx_line | output | 10 | Transmit pair toward the line |
| framer_data | output | 10 | Pair fed to the framer input |
| clk_sel_local | output | 1 | Framer/buffer clock select: 1 local, 0 recovered |
| filter_hold | output | 1 | Holds the repeat filter disabled |
| selftest_run | output | 1 | Self-test running |
| selftest_irq | output | 1 | One-cycle self-test completion interrupt |

## Verification
A write changes the control bits on the edge that samples it. `selftest_run` and `filter_hold` show the new bits straight after that edge, while `rx_pair`, `tx_line`, `framer_data` and `clk_sel_local` change one edge later. Line symbols need two more edges to form a pair before they reach `framer_data`. The bench therefore drives each table vector as one write and holds its inputs for four further cycles, so every path has settled before it samples at a falling edge. The directed self-test steps sample one falling edge after each edge that should move `selftest_run` or `selftest_irq`.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // control word layout
  localparam int CTRL_W    = 6;
  localparam int B_PBLOOP  = 0;
  localparam int B_FRLOOP  = 1;
  localparam int B_REMLOOP = 2;
  localparam int B_BYPASS  = 3;
  localparam int B_FILTER  = 4;
  localparam int B_SELFTST = 5;

  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_OFF   = 3'd0;
  localparam logic [STATE_W-1:0] ST_MAINT = 3'd1;

  typedef struct packed {
    logic selftest;
    logic filter;
    logic bypass;
    logic remote;
    logic fr_loop;
    logic pb_loop;
  } ctrl_t;
endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/spc_ctrl_regs.sv
module spc_ctrl_regs
  import spc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [STATE_W-1:0] mgmt_state,
  output ctrl_t              ctrl_q
);
  ctrl_t ctrl_d;
  logic  local_wr_ok;

  assign local_wr_ok = (mgmt_state == ST_OFF) || (mgmt_state == ST_MAINT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.remote   = wr_data[B_REMLOOP];
      ctrl_d.bypass   = wr_data[B_BYPASS];
      ctrl_d.filter   = wr_data[B_FILTER];
      ctrl_d.selftest = wr_data[B_SELFTST];
      if (local_wr_ok) begin
        ctrl_d.pb_loop = wr_data[B_PBLOOP];
        ctrl_d.fr_loop = wr_data[B_FRLOOP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/spc_selftest.sv
module spc_selftest (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic start_bit,
  input  logic done_in,
  output logic active,
  output logic irq_q
);
  logic done_q, done_d, irq_d;

  assign active = start_bit && !done_q;

  always_comb begin
    irq_d  = active && done_in;
    done_d = done_q;
    if (!start_bit)  done_d = 1'b0;
    else if (irq_d)  done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/spc_sym_pack.sv
module spc_sym_pack #(
  parameter int SYM_W = 5,
  parameter int SYMS  = 2,
  localparam int PAIR_W = SYM_W * SYMS,
  localparam int CNT_W  = (SYMS > 1) ? $clog2(SYMS) : 1
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [SYM_W-1:0]  sym_in,
  output logic [PAIR_W-1:0] pair_q
);
  logic [SYMS-1:0][SYM_W-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       last;

  assign last = (cnt_q == CNT_W'(SYMS - 1));

  always_comb begin
    hist_d    = hist_q << SYM_W;
    hist_d[0] = sym_in;
    cnt_d     = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      pair_q <= '0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      if (last) pair_q <= hist_d;
    end
  end
endmodule

// File: rtl/sym_path_ctrl.sv
module sym_path_ctrl
  import spc_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int SYMS  = 2,
  localparam int PAIR_W = SYM_W * SYMS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [STATE_W-1:0] mgmt_state,
  input  logic               cfg_override,
  input  logic               cipher_loop,
  input  logic               scrub_req,
  input  logic               selftest_done,
  input  logic [PAIR_W-1:0]  tx_pair,
  input  logic [PAIR_W-1:0]  eb_pair,
  input  logic [SYM_W-1:0]   rx_line,
  output logic [PAIR_W-1:0]  rx_pair,
  output logic [PAIR_W-1:0]  tx_line,
  output logic [PAIR_W-1:0]  framer_data,
  output logic               clk_sel_local,
  output logic               filter_hold,
  output logic               selftest_run,
  output logic               selftest_irq
);
  localparam logic [PAIR_W-1:0] IDLE_PAIR = '1;

  logic              rst_sync_n;
  ctrl_t             ctrl_q;
  logic              st_active;
  logic [PAIR_W-1:0] line_pair;
  logic              lb_pb_q, lb_fr_q;
  logic              gate_on, byp_eff, fr_eff, rem_eff;
  logic [PAIR_W-1:0] rx_post;
  logic [PAIR_W-1:0] rx_pair_d, tx_line_d, framer_d;

  spc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  spc_ctrl_regs u_regs (
    .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en),
    .wr_data(wr_data), .mgmt_state(mgmt_state), .ctrl_q(ctrl_q)
  );

  spc_selftest u_st (
    .clk(clk), .rst_sync_n(rst_sync_n), .start_bit(ctrl_q.selftest),
    .done_in(selftest_done), .active(st_active), .irq_q(selftest_irq)
  );

  spc_sym_pack #(.SYM_W(SYM_W), .SYMS(SYMS)) u_pack (
    .clk(clk), .rst_sync_n(rst_sync_n), .sym_in(rx_line), .pair_q(line_pair)
  );

  assign lb_pb_q = ctrl_q.pb_loop;
  assign lb_fr_q = ctrl_q.fr_loop;

  // path selection with fixed priority: post-buffer, framer, remote
  always_comb begin
    gate_on = (mgmt_state == ST_MAINT) || cfg_override;
    byp_eff = gate_on && ctrl_q.bypass;
    fr_eff  = !lb_pb_q && (lb_fr_q || st_active);
    rem_eff = gate_on && ctrl_q.remote && !lb_pb_q && !fr_eff && !cipher_loop;
    rx_post = lb_pb_q ? tx_pair : eb_pair;
  end

  always_comb begin
    if (byp_eff) rx_pair_d = scrub_req ? IDLE_PAIR : tx_pair;
    else         rx_pair_d = rx_post;
    tx_line_d = rem_eff ? rx_post : tx_pair;
    framer_d  = fr_eff ? tx_pair : line_pair;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_pair       <= '0;
      tx_line       <= '0;
      framer_data   <= '0;
      clk_sel_local <= 1'b0;
    end else begin
      rx_pair       <= rx_pair_d;
      tx_line       <= tx_line_d;
      framer_data   <= framer_d;
      clk_sel_local <= fr_eff;
    end
  end

  assign filter_hold  = ctrl_q.filter;
  assign selftest_run = st_active;
endmodule

// File: rtl/spc_chk.sv
module spc_chk
  import spc_pkg::*;
#(
  parameter int PAIR_W = 10
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               wr_en,
  input logic [STATE_W-1:0] mgmt_state,
  input logic               lb_fr_q,
  input logic               lb_pb_q,
  input logic               byp_eff,
  input logic               rem_eff,
  input logic               scrub_req,
  input logic               st_active,
  input logic [PAIR_W-1:0]  rx_pair,
  input logic [PAIR_W-1:0]  tx_pair,
  input logic [PAIR_W-1:0]  eb_pair,
  input logic [PAIR_W-1:0]  tx_line,
  input logic               clk_sel_local,
  input logic               selftest_irq
);
  assert_local_wr_locked_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && mgmt_state != ST_OFF && mgmt_state != ST_MAINT)
      |=> ($stable(lb_fr_q) && $stable(lb_pb_q)));

  assert_bypass_idle_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (byp_eff && scrub_req) |=> (rx_pair == {PAIR_W{1'b1}}));

  assert_bypass_tx_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (byp_eff && !scrub_req) |=> (rx_pair == $past(tx_pair)));

  assert_remote_loop_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rem_eff |=> (tx_line == $past(eb_pair)));

  assert_selftest_forces_loop_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_active && !lb_pb_q) |=> clk_sel_local);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    selftest_irq |=> !selftest_irq);
endmodule

bind sym_path_ctrl spc_chk #(.PAIR_W(PAIR_W)) u_chk (.*);

// File: tb/tb_sym_path_ctrl.sv
module tb_sym_path_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_OFF = 3'd0, S_MNT = 3'd1, S_ACT = 3'd4;
  localparam logic [9:0] T = 10'h155, E = 10'h0AA, L = 10'h18C, I = 10'h3FF;
  localparam logic [4:0] SYM = 5'h0C;

  typedef struct packed {
    logic [2:0] st;
    logic       cfg;
    logic       ciph;
    logic       scr;
    logic       wr;
    logic [5:0] w;
    logic [9:0] rx;
    logic [9:0] txl;
    logic [9:0] fr;
    logic       ck;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{S_ACT,1'b0,1'b0,1'b0,1'b1,6'b000000,E,T,L,1'b0}, // 0 base path R4 R6
    '{S_ACT,1'b0,1'b0,1'b0,1'b1,6'b000011,E,T,L,1'b0}, // 1 R1 write ignored
    '{S_OFF,1'b0,1'b0,1'b0,1'b1,6'b000010,E,T,T,1'b1}, // 2 R1 R6 framer loop
    '{S_MNT,1'b0,1'b0,1'b0,1'b1,6'b000001,T,T,L,1'b0}, // 3 R7 post-buffer loop
    '{S_MNT,1'b0,1'b0,1'b0,1'b1,6'b001000,T,T,L,1'b0}, // 4 R4 bypass
    '{S_MNT,1'b0,1'b0,1'b1,1'b1,6'b001000,I,T,L,1'b0}, // 5 R3 scrub idle
    '{S_ACT,1'b0,1'b0,1'b0,1'b1,6'b001000,E,T,L,1'b0}, // 6 R2 not in effect
    '{S_ACT,1'b1,1'b0,1'b0,1'b1,6'b001000,T,T,L,1'b0}, // 7 R2 override
    '{S_ACT,1'b0,1'b0,1'b0,1'b1,6'b000100,E,T,L,1'b0}, // 8 R2 remote gated
    '{S_MNT,1'b0,1'b0,1'b0,1'b1,6'b000100,E,E,L,1'b0}, // 9 R5 remote
    '{S_MNT,1'b0,1'b1,1'b0,1'b0,6'b000000,E,T,L,1'b0}, // 10 R5 cipher blocks
    '{S_MNT,1'b0,1'b0,1'b0,1'b1,6'b000110,E,T,T,1'b1}, // 11 R7 framer beats remote
    '{S_OFF,1'b0,1'b0,1'b0,1'b1,6'b000011,T,T,L,1'b0}, // 12 R7 post-buffer beats framer
    '{S_ACT,1'b1,1'b0,1'b0,1'b1,6'b000100,T,T,L,1'b0}  // 13 R1 R7 clear ignored
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_data;
  logic [2:0] mgmt_state;
  logic       cfg_override, cipher_loop, scrub_req, selftest_done;
  logic [9:0] tx_pair, eb_pair;
  logic [4:0] rx_line;
  logic [9:0] rx_pair, tx_line, framer_data;
  logic       clk_sel_local, filter_hold, selftest_run, selftest_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_path_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mgmt_state(mgmt_state), .cfg_override(cfg_override),
    .cipher_loop(cipher_loop), .scrub_req(scrub_req),
    .selftest_done(selftest_done), .tx_pair(tx_pair), .eb_pair(eb_pair),
    .rx_line(rx_line), .rx_pair(rx_pair), .tx_line(tx_line),
    .framer_data(framer_data), .clk_sel_local(clk_sel_local),
    .filter_hold(filter_hold), .selftest_run(selftest_run),
    .selftest_irq(selftest_irq)
  );

  task automatic check(input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [2:0] st, input logic [5:0] w);
    mgmt_state = st;
    wr_data    = w;
    wr_en      = 1'b1;
    cyc(1);
    wr_en      = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mgmt_state = S_OFF;
    cfg_override = 1'b0; cipher_loop = 1'b0; scrub_req = 1'b0;
    selftest_done = 1'b0; tx_pair = T; eb_pair = E; rx_line = SYM;
    cyc(5);
    // R11 reset state
    check("R11 rx_pair", rx_pair, 10'h000);
    check("R11 tx_line", tx_line, 10'h000);
    check("R11 framer_data", framer_data, 10'h000);
    check("R11 flags", {6'd0, clk_sel_local, filter_hold, selftest_run, selftest_irq}, 10'h000);
    rst_n = 1'b1;
    cyc(4);

    for (int v = 0; v < NV; v++) begin
      cfg_override = VECS[v].cfg;
      cipher_loop  = VECS[v].ciph;
      scrub_req    = VECS[v].scr;
      mgmt_state   = VECS[v].st;
      wr_data      = VECS[v].w;
      wr_en        = VECS[v].wr;
      cyc(1);
      wr_en = 1'b0;
      cyc(4);
      check($sformatf("vec%0d R4 rx_pair", v), rx_pair, VECS[v].rx);
      check($sformatf("vec%0d R5 tx_line", v), tx_line, VECS[v].txl);
      check($sformatf("vec%0d R6 framer_data", v), framer_data, VECS[v].fr);
      check($sformatf("vec%0d R6 clk_sel_local", v), {9'd0, clk_sel_local}, {9'd0, VECS[v].ck});
    end

    // R6 pair ordering: earlier symbol in upper half
    cfg_override = 1'b0; cipher_loop = 1'b0;
    write(S_OFF, 6'b000000);
    for (int k = 0; k < 8; k++) begin
      rx_line = k[0] ? 5'h03 : 5'h1C;
      cyc(1);
    end
    check("R6 pair from alternating symbols",
          ((framer_data == 10'h383) || (framer_data == 10'h07C)) ? 10'd1 : 10'd0, 10'd1);
    rx_line = SYM;
    cyc(4);

    // R8 self-test start forces framer loop
    write(S_ACT, 6'b100000);
    check("R8 selftest_run after start", {9'd0, selftest_run}, 10'd1);
    cyc(2);
    check("R8 forced clk_sel_local", {9'd0, clk_sel_local}, 10'd1);
    check("R8 forced framer_data", framer_data, T);
    // completion
    selftest_done = 1'b1;
    cyc(1);
    selftest_done = 1'b0;
    check("R8 irq on completion", {9'd0, selftest_irq}, 10'd1);
    check("R8 run ends on completion", {9'd0, selftest_run}, 10'd0);
    cyc(1);
    check("R8 irq lasts one cycle", {9'd0, selftest_irq}, 10'd0);
    // R9 rewrite of 1 does not restart
    write(S_ACT, 6'b100000);
    check("R9 no restart without clear", {9'd0, selftest_run}, 10'd0);
    write(S_ACT, 6'b000000);
    write(S_ACT, 6'b100000);
    check("R9 restart after clear", {9'd0, selftest_run}, 10'd1);
    // R8 abort: clear before completion, then done gives no irq
    write(S_ACT, 6'b000000);
    check("R8 abort stops run", {9'd0, selftest_run}, 10'd0);
    selftest_done = 1'b1;
    cyc(1);
    selftest_done = 1'b0;
    check("R8 no irq after abort", {9'd0, selftest_irq}, 10'd0);
    cyc(2);
    check("R8 loop released after abort", {9'd0, clk_sel_local}, 10'd0);

    // R10 filter hold, written in a non-maintenance state (R2)
    write(S_ACT, 6'b010000);
    check("R10 filter_hold set", {9'd0, filter_hold}, 10'd1);
    write(S_ACT, 6'b000000);
    check("R10 filter_hold cleared", {9'd0, filter_hold}, 10'd0);

    // R11 reset in mid-run clears outputs
    write(S_MNT, 6'b011001);
    cyc(3);
    rst_n = 1'b0;
    #1;
    check("R11 async reset rx_pair", rx_pair, 10'h000);
    check("R11 async reset filter_hold", {9'd0, filter_hold}, 10'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule